// File: doc/BRIEF.md
# Pulse-Count Register Writer

This block turns one slow control line into writes of a small configuration register bank. The line is sampled by a fast system clock through a two-flop synchronizer. Level durations on the line, counted in clock cycles, enable the block (a long high) and shut it down (a long low). A shutdown also clears every register. Once the block is enabled, a burst of low-going dips encodes a register address. The number of rising edges minus one gives the value. A long enough high interval closes that burst, and a second burst then encodes the data word in the same way. A second high interval commits the word.

Framing depends only on the high intervals. The high interval after the address has both a minimum and a maximum length. The high interval after the data has only a minimum. High phases shorter than the minimum do not close a field, and counting carries on into the same field. A burst with too many edges is thrown away. Every write must send its own address followed by its own data. A commit produces a one-cycle strobe that carries the address and data, and the register bank takes the word from that strobe. All thresholds are parameters given in clock cycles.

Top module: `pulse_reg_writer`

## Requirements
- R1: After reset, `en_o` is 0, `wr_o` is 0 and all 32 registers in `regs_o` are zero.
- R2: While disabled, a high phase of at least `T_SU` cycles on the synchronized line sets `en_o`. A shorter high phase leaves `en_o` at 0.
- R3: While enabled, a low phase of `T_SD` cycles clears `en_o`, pulses `reg_rst_o` for exactly one cycle and returns every register to zero. A shorter low phase has no effect.
- R4: A field value is its count of rising edges minus one: 1 to 32 edges give addresses 0 to 31, and 1 to 64 edges give data 0 to 63.
- R5: An address burst ends only when the line stays high for `T_HOLDA_MIN` cycles. Edges after a shorter high phase add to the same address count.
- R6: After an address hold, a high phase of up to `T_HOLDA_MAX` cycles still accepts data. At `T_HOLDA_MAX+1` cycles the transfer is dropped and the next burst is taken as an address.
- R7: Data commits after a high phase of at least `T_HOLDD_MIN` cycles, with no upper limit. The commit raises `wr_o` for one cycle with `wr_addr_o` and `wr_data_o`, and the addressed 6-bit field of `regs_o` (bits addr*6 up to addr*6+5) takes the data.
- R8: An address burst of more than 32 edges, or a data burst of more than 64 edges, produces no write. The next burst is then taken as an address.
- R9: After every commit the next burst is an address, so a data burst repeated without its address is decoded as a new address.
- R10: While disabled, pulse activity with high phases shorter than `T_SU` produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Asynchronous single-wire control line |
| en_o | output | 1 | Device enabled |
| reg_rst_o | output | 1 | One-cycle pulse when shutdown clears the registers |
| wr_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 5 | Address of the current write |
| wr_data_o | output | 6 | Data of the current write |
| regs_o | output | 192 | Register bank, register n in bits n*6+5 down to n*6 |

## Verification
Two decisions can become due in the same cycle. One is the expiry of the address-hold maximum. The other is the falling edge that opens the data burst. The bench drives a high phase of exactly `T_HOLDA_MAX` cycles, which must still deliver the data, and then one of `T_HOLDA_MAX+1` cycles, which must drop the transfer. In the second case the data burst must be decoded as an address, and the bench judges this at the strobe port and in the register bank.

// File: rtl/prw_pkg.sv
package prw_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } prw_state_e;
endpackage

// File: rtl/prw_line_timer.sv
module prw_line_timer #(
  parameter int RUN_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  output logic             lvl_o,
  output logic             rise_o,
  output logic [RUN_W-1:0] run_o
);
  logic [1:0]       sync_q;
  logic             lvl_q, rise_q;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
      lvl_q  <= 1'b0;
      rise_q <= 1'b0;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      lvl_q  <= sync_q[1];
      rise_q <= sync_q[1] & ~lvl_q;
      if (sync_q[1] != lvl_q) run_q <= RUN_W'(1);
      else if (run_q != '1)   run_q <= run_q + 1'b1;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = rise_q;
  assign run_o  = run_q;
endmodule

// File: rtl/prw_framer.sv
module prw_framer
  import prw_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 6,
  parameter int RUN_W       = 9,
  parameter int T_SU        = 40,
  parameter int T_SD        = 300,
  parameter int T_HOLDA_MIN = 20,
  parameter int T_HOLDA_MAX = 120,
  parameter int T_HOLDD_MIN = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lvl_i,
  input  logic              rise_i,
  input  logic [RUN_W-1:0]  run_i,
  output logic              en_o,
  output logic              sd_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W   = ((ADDR_W > DATA_W) ? ADDR_W : DATA_W) + 2;
  localparam int A_EDGES = 1 << ADDR_W;
  localparam int D_EDGES = 1 << DATA_W;

  prw_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              wr_q, sd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      wr_q    <= 1'b0;
      sd_q    <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      sd_q <= 1'b0;
      if (state_q == ST_OFF) begin
        cnt_q <= '0;
        if (lvl_i && run_i == RUN_W'(T_SU)) state_q <= ST_ADDR;
      end else if (!lvl_i && run_i == RUN_W'(T_SD)) begin
        state_q <= ST_OFF;
        sd_q    <= 1'b1;
        cnt_q   <= '0;
      end else if (rise_i) begin
        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      end else if (lvl_i) begin
        if (state_q == ST_ADDR && cnt_q != '0 && run_i == RUN_W'(T_HOLDA_MIN)) begin
          cnt_q <= '0;
          if (cnt_q <= CNT_W'(A_EDGES)) begin
            addr_q  <= ADDR_W'(cnt_q - 1'b1);
            state_q <= ST_DATA;
          end
        end else if (state_q == ST_DATA && cnt_q == '0
                     && run_i == RUN_W'(T_HOLDA_MAX + 1)) begin
          state_q <= ST_ADDR;  // address hold too long: drop
        end else if (state_q == ST_DATA && cnt_q != '0
                     && run_i == RUN_W'(T_HOLDD_MIN)) begin
          cnt_q   <= '0;
          state_q <= ST_ADDR;
          if (cnt_q <= CNT_W'(D_EDGES)) begin
            data_q <= DATA_W'(cnt_q - 1'b1);
            wr_q   <= 1'b1;
          end
        end
      end
    end
  end

  assign en_o   = (state_q != ST_OFF);
  assign sd_o   = sd_q;
  assign wr_o   = wr_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/prw_regfile.sv
module prw_regfile #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 6
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clr_i,
  input  logic                           wr_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              data_i,
  output logic [(1<<ADDR_W)*DATA_W-1:0]  regs_o
);
  localparam int N_REGS = 1 << ADDR_W;

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             q <= '0;
      else if (clr_i)                          q <= '0;
      else if (wr_i && addr_i == ADDR_W'(i))   q <= data_i;
    end
    assign regs_o[i*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/pulse_reg_writer.sv
module pulse_reg_writer #(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 6,
  parameter int T_SU        = 40,
  parameter int T_SD        = 300,
  parameter int T_HOLDA_MIN = 20,
  parameter int T_HOLDA_MAX = 120,
  parameter int T_HOLDD_MIN = 20
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          line_i,
  output logic                          en_o,
  output logic                          reg_rst_o,
  output logic                          wr_o,
  output logic [ADDR_W-1:0]             wr_addr_o,
  output logic [DATA_W-1:0]             wr_data_o,
  output logic [(1<<ADDR_W)*DATA_W-1:0] regs_o
);
  localparam int M1    = (T_SU > T_SD) ? T_SU : T_SD;
  localparam int M2    = (T_HOLDA_MAX + 1 > T_HOLDD_MIN) ? T_HOLDA_MAX + 1 : T_HOLDD_MIN;
  localparam int M3    = (M1 > M2) ? M1 : M2;
  localparam int T_TOP = (M3 > T_HOLDA_MIN) ? M3 : T_HOLDA_MIN;
  localparam int RUN_W = $clog2(T_TOP + 2);

  logic             lvl, rise;
  logic [RUN_W-1:0] run;

  prw_line_timer #(.RUN_W(RUN_W)) u_timer (
    .clk_i, .rst_ni, .line_i,
    .lvl_o(lvl), .rise_o(rise), .run_o(run)
  );

  prw_framer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RUN_W(RUN_W), .T_SU(T_SU), .T_SD(T_SD),
    .T_HOLDA_MIN(T_HOLDA_MIN), .T_HOLDA_MAX(T_HOLDA_MAX), .T_HOLDD_MIN(T_HOLDD_MIN)
  ) u_framer (
    .clk_i, .rst_ni, .lvl_i(lvl), .rise_i(rise), .run_i(run),
    .en_o, .sd_o(reg_rst_o), .wr_o, .addr_o(wr_addr_o), .data_o(wr_data_o)
  );

  prw_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .clr_i(reg_rst_o), .wr_i(wr_o),
    .addr_i(wr_addr_o), .data_i(wr_data_o), .regs_o
  );
endmodule

// File: rtl/pulse_reg_writer_chk.sv
module pulse_reg_writer_chk #(
  parameter int REGS_W = 192
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_o,
  input logic              reg_rst_o,
  input logic              wr_o,
  input logic [REGS_W-1:0] regs_o
);
  AST_WR_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> en_o); // R10
  AST_WR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o); // R7
  AST_RST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rst_o |=> !reg_rst_o); // R3
  AST_RST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rst_o |=> (regs_o == '0)); // R3
  AST_EN_FALL_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_o) |-> reg_rst_o); // R3
  AST_EN_RISE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_o) |-> !wr_o); // R2
endmodule

bind pulse_reg_writer pulse_reg_writer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_o(en_o), .reg_rst_o(reg_rst_o),
  .wr_o(wr_o), .regs_o(regs_o)
);

// File: tb/pulse_reg_writer_bench.sv
`timescale 1ns/1ps
module pulse_reg_writer_bench;
  localparam int T_SU = 40, T_SD = 300, HA_MIN = 20, HA_MAX = 120, HD_MIN = 20;

  logic         clk = 1'b0, rst_n = 1'b0, line = 1'b0;
  logic         en, rrst, wr;
  logic [4:0]   waddr;
  logic [5:0]   wdata;
  logic [191:0] regs;
  int n_tests = 0, n_fail = 0, wr_cnt = 0, rst_cnt = 0;
  int last_a = -1, last_d = -1;
  bit done = 0;

  always #2.5 clk = ~clk;

  pulse_reg_writer u_pulse_reg_writer (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .en_o(en), .reg_rst_o(rrst),
    .wr_o(wr), .wr_addr_o(waddr), .wr_data_o(wdata), .regs_o(regs)
  );

  always @(negedge clk) begin
    if (wr) begin wr_cnt++; last_a = waddr; last_d = wdata; end
    if (rrst) rst_cnt++;
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string r, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  function automatic int reg_at(int a); return int'(regs[a*6 +: 6]); endfunction

  // n rising edges; line ends high
  task automatic train(int n);
    for (int i = 0; i < n; i++) begin
      line = 1'b0; cyc(3); line = 1'b1;
      if (i < n - 1) cyc(3);
    end
  endtask

  task automatic write(int a, int d, int ha, int hd);
    train(a + 1); cyc(ha); train(d + 1); cyc(hd); cyc(4);
  endtask

  task automatic t_reset;
    chk("R1 en", en, 0); chk("R1 wr", wr, 0);
    for (int a = 0; a < 32; a++) chk("R1 reg", reg_at(a), 0);
  endtask

  task automatic t_enable;
    line = 1'b1; cyc(T_SU - 10); line = 1'b0; cyc(8);
    chk("R2 short high", en, 0);
    line = 1'b1; cyc(T_SU + 6);
    chk("R2 enable", en, 1);
    cyc(20);
  endtask

  task automatic t_basic;
    int w0 = wr_cnt;
    write(5, 3, 30, 30);
    chk("R7 strobe", wr_cnt - w0, 1); chk("R4 addr", last_a, 5);
    chk("R4 data", last_d, 3); chk("R7 reg", reg_at(5), 3);
    write(31, 63, HA_MIN, 200);
    chk("R4 max addr", last_a, 31); chk("R4 max data", reg_at(31), 63);
    write(0, 0, 25, HD_MIN);
    chk("R4 zero", wr_cnt - w0, 3); chk("R4 reg0", reg_at(0), 0);
  endtask

  task automatic t_split;
    train(2); cyc(HA_MIN - 10); train(2); cyc(30);
    train(8); cyc(30); cyc(4);
    chk("R5 split addr", last_a, 3); chk("R5 split reg", reg_at(3), 7);
  endtask

  task automatic t_holdmax;
    int w0 = wr_cnt;
    write(6, 9, HA_MAX, 30);
    chk("R6 exact max", reg_at(6), 9);
    train(8); cyc(HA_MAX + 1);
    train(10); cyc(30); cyc(HA_MAX + 30);
    chk("R6 dropped count", wr_cnt - w0, 1);
    chk("R6 dropped reg7", reg_at(7), 0);
    chk("R6 reg9 untouched", reg_at(9), 0);
  endtask

  task automatic t_overflow;
    int w0 = wr_cnt;
    train(33); cyc(30); train(5); cyc(30); cyc(HA_MAX + 30);
    chk("R8 addr ovf", wr_cnt - w0, 0);
    chk("R8 reg4", reg_at(4), 0);
    train(3); cyc(30); train(65); cyc(30); cyc(4);
    chk("R8 data ovf", wr_cnt - w0, 0);
    chk("R8 reg2", reg_at(2), 0);
    write(2, 5, 30, 30);
    chk("R8 recovery", reg_at(2), 5);
  endtask

  task automatic t_pairing;
    write(10, 4, 30, 30);
    train(6); cyc(30); train(3); cyc(30); cyc(4);
    chk("R9 first", reg_at(10), 4);
    chk("R9 reparsed addr", last_a, 5);
    chk("R9 reparsed data", reg_at(5), 2);
  endtask

  task automatic t_shutdown;
    int r0 = rst_cnt, w0;
    line = 1'b0; cyc(T_SD - 20);
    chk("R3 short low", en, 1); chk("R3 reg kept", reg_at(5), 2);
    cyc(30);
    chk("R3 disabled", en, 0); chk("R3 pulse", rst_cnt - r0, 1);
    for (int a = 0; a < 32; a++) chk("R3 cleared", reg_at(a), 0);
    w0 = wr_cnt;
    for (int k = 0; k < 4; k++) begin train(4); cyc(T_SU - 15); end
    line = 1'b0; cyc(10);
    chk("R10 no write", wr_cnt - w0, 0); chk("R10 still off", en, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3); t_reset(); rst_n = 1'b1; cyc(3);
    t_reset();
    t_enable();
    t_basic();
    t_split();
    t_holdmax();
    t_overflow();
    t_pairing();
    t_shutdown();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule